// File: doc/BRIEF.md
# Two-Group Rotating Bus Arbiter

This block decides which of several masters on a shared PCI-style bus may drive the next transaction. There are five masters by default: the local host and four external devices. Each master raises an active-low request. The arbiter answers with at most one active-low grant. It watches the bus framing and ready strobes to tell whether the bus is busy or idle, and to see when a new transaction begins.

A per-master group bit sorts the masters into a high group and a low group. Inside the high group, the masters rotate in index order. The whole low group takes one extra slot at the end of that rotation, and the low-group masters rotate among themselves inside the slot. Each transaction start moves the rotation on, so the master that opened the transaction becomes the last candidate. Between starts, the grant follows the best current request and pre-empts a lower-priority grant.

A master that is granted but does not start a transaction within 16 idle cycles loses its grant. It stays shut out until it releases its request. When the grant moves while the bus is idle, there is always one cycle with no grant in between. When the bus is busy, the grant may move from one master to another in a single step.

Top module: `pci_grp_arbiter`

## Requirements
- R1: While reset is low, and in the first cycle after reset with no request, every grant output is high (deasserted). After reset, master 0 is first in both rotations.
- R2: At most one grant output is low in any cycle, and with no request pending no grant is issued.
- R3: Bit i of `hi_grp_i` set to 1 puts master i in the high group, and 0 puts it in the low group. The high rotation runs through the high-group masters in index order and then through one slot that stands for the whole low group. Right after reset, a requesting high-group master therefore beats any low-group master.
- R4: When the low-group slot wins, the grant goes to the next requesting low-group master in that group's own index rotation.
- R5: With every master in one group, either group, arbitration is plain rotation over all masters in index order.
- R6: A transaction start is `frame_ni` low in a cycle after a cycle in which it was high. At a start, the granted master becomes last in its own group's rotation, and the master after it becomes first. If that master is in the low group, the high rotation restarts with the low slot last. The new order applies from the next cycle.
- R7: The grant tracks the highest-priority eligible request. A higher-priority request withdraws the current grant.
- R8: While the bus is idle (`frame_ni` and `irdy_ni` both high), a grant change always passes through one cycle with no grant. This covers a change caused by a dropped request.
- R9: While the bus is busy (`frame_ni` or `irdy_ni` low), the grant moves from one master to another in the same clock.
- R10: A grant held for 16 consecutive idle cycles without a transaction start is removed after the 16th cycle.
- R11: A master that timed out gets no grant until its request has been high for at least one clock. After that, it competes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | N_MASTERS | Request per master, active low |
| hi_grp_i | input | N_MASTERS | Group select per master, 1 = high group |
| frame_ni | input | 1 | Bus framing strobe, active low |
| irdy_ni | input | 1 | Initiator ready strobe, active low |
| gnt_no | output | N_MASTERS | Grant per master, active low |

## Verification
Some properties are checked by assertions on every cycle:
- no more than one grant is held;
- an idle bus never sees a grant change straight to another master;
- a timeout always empties the grant on the next cycle;
- a locked-out master never holds a grant.

The other behaviours can only be shown by the bench's scenarios:
- the order in which masters win, across both groups and across transaction starts;
- the all-high and all-low rotation cases;
- the exact 16-cycle timeout;
- the release-and-rerequest sequence that ends a lockout.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;
  // grant register turnover for one cycle
  typedef enum logic [1:0] {
    TURN_HOLD,
    TURN_MOVE,
    TURN_GAP,
    TURN_DROP
  } turn_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int WIDTH = 5,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] req_i,
  input  logic [IW-1:0]    ptr_i,
  output logic [WIDTH-1:0] gnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int k = 0; k < WIDTH; k++) begin
      int idx;
      idx = int'(ptr_i) + k;
      if (idx >= WIDTH) idx = idx - WIDTH;
      if (!found && req_i[idx[IW-1:0]]) begin
        gnt_o[idx[IW-1:0]] = 1'b1;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_noshow_guard.sv
module arb_noshow_guard #(
  parameter int N_MASTERS = 5,
  parameter int TIMEOUT   = 16,
  localparam int CW = $clog2(TIMEOUT)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 active_i,   // grant held on idle bus
  input  logic [N_MASTERS-1:0] gnt_i,
  input  logic [N_MASTERS-1:0] req_ni,
  output logic                 timeout_o,
  output logic [N_MASTERS-1:0] lock_o
);
  logic [CW-1:0]        cnt_q;
  logic [N_MASTERS-1:0] lock_q;

  assign timeout_o = active_i && (cnt_q == CW'(TIMEOUT - 1));
  assign lock_o    = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= '0;
    end else begin
      if (!active_i || timeout_o) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
      // lock holds only while request stays low
      lock_q <= (lock_q & ~req_ni) | (timeout_o ? gnt_i : '0);
    end
  end
endmodule

// File: rtl/pci_grp_arbiter.sv
module pci_grp_arbiter
  import pci_arb_pkg::*;
#(
  parameter int N_MASTERS = 5,
  parameter int TIMEOUT   = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_MASTERS-1:0] req_ni,
  input  logic [N_MASTERS-1:0] hi_grp_i,
  input  logic                 frame_ni,
  input  logic                 irdy_ni,
  output logic [N_MASTERS-1:0] gnt_no
);
  localparam int LO_IW = $clog2(N_MASTERS);
  localparam int HI_IW = $clog2(N_MASTERS + 1);

  logic [N_MASTERS-1:0] gnt_q, gnt_d, winner, eligible, lock_q;
  logic [N_MASTERS-1:0] lo_req, lo_pick;
  logic [N_MASTERS:0]   hi_req, hi_pick;
  logic [HI_IW-1:0]     hi_ptr_q;
  logic [LO_IW-1:0]     lo_ptr_q, init_idx;
  logic                 frame_q, bus_idle, start, to_hit;
  turn_e                turn;

  assign bus_idle = frame_ni && irdy_ni;
  assign start    = !frame_ni && frame_q && (gnt_q != '0);
  assign eligible = ~req_ni & ~lock_q;
  assign lo_req   = eligible & ~hi_grp_i;
  assign hi_req   = {|lo_req, eligible & hi_grp_i};

  arb_rr_pick #(.WIDTH(N_MASTERS + 1)) u_hi_pick (
    .req_i(hi_req), .ptr_i(hi_ptr_q), .gnt_o(hi_pick)
  );

  arb_rr_pick #(.WIDTH(N_MASTERS)) u_lo_pick (
    .req_i(lo_req), .ptr_i(lo_ptr_q), .gnt_o(lo_pick)
  );

  assign winner = hi_pick[N_MASTERS] ? lo_pick : hi_pick[N_MASTERS-1:0];

  arb_noshow_guard #(.N_MASTERS(N_MASTERS), .TIMEOUT(TIMEOUT)) u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (bus_idle && (gnt_q != '0)),
    .gnt_i    (gnt_q),
    .req_ni   (req_ni),
    .timeout_o(to_hit),
    .lock_o   (lock_q)
  );

  // turnover: idle bus moves only through an empty cycle
  always_comb begin
    if (to_hit)                turn = TURN_DROP;
    else if (!bus_idle)        turn = TURN_MOVE;
    else if (gnt_q == '0)      turn = TURN_MOVE;
    else if (winner != gnt_q)  turn = TURN_GAP;
    else                       turn = TURN_HOLD;
  end

  always_comb begin
    unique case (turn)
      TURN_MOVE: gnt_d = winner;
      TURN_GAP,
      TURN_DROP: gnt_d = '0;
      default:   gnt_d = gnt_q;
    endcase
  end

  always_comb begin
    init_idx = '0;
    for (int i = 0; i < N_MASTERS; i++)
      if (gnt_q[i]) init_idx = LO_IW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q    <= '0;
      frame_q  <= 1'b1;
      hi_ptr_q <= '0;
      lo_ptr_q <= '0;
    end else begin
      gnt_q   <= gnt_d;
      frame_q <= frame_ni;
      if (start) begin
        if (hi_grp_i[init_idx]) begin
          hi_ptr_q <= HI_IW'(init_idx) + 1'b1;
        end else begin
          hi_ptr_q <= '0;
          lo_ptr_q <= (init_idx == LO_IW'(N_MASTERS - 1)) ? '0 : init_idx + 1'b1;
        end
      end
    end
  end

  assign gnt_no = ~gnt_q;

  p_one_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));

  p_idle_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_idle && gnt_q != '0) |=> (gnt_q == $past(gnt_q) || gnt_q == '0));

  p_timeout_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_hit |=> (gnt_q == '0));

  p_lock_block_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q & lock_q) == '0);
endmodule

// File: tb/pci_grp_arbiter_test.sv
`timescale 1ns/100ps
module pci_grp_arbiter_test;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_ni = '1;
  logic [N-1:0] hi_grp_i = '0;
  logic         frame_ni = 1'b1;
  logic         irdy_ni = 1'b1;
  logic [N-1:0] gnt_no;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pci_grp_arbiter #(.N_MASTERS(N), .TIMEOUT(16)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_ni(req_ni), .hi_grp_i(hi_grp_i),
    .frame_ni(frame_ni), .irdy_ni(irdy_ni), .gnt_no(gnt_no)
  );

  // {req(active high), group, frame asserted, irdy asserted, expected grant(active high)}
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {5'b00000, 5'b00011, 1'b0, 1'b0, 5'b00000},
    {5'b10100, 5'b00011, 1'b0, 1'b0, 5'b00100},
    {5'b10101, 5'b00011, 1'b0, 1'b0, 5'b00000},
    {5'b10101, 5'b00011, 1'b0, 1'b0, 5'b00001},
    {5'b10101, 5'b00011, 1'b1, 1'b0, 5'b00001},
    {5'b10100, 5'b00011, 1'b1, 1'b1, 5'b00100},
    {5'b10100, 5'b00011, 1'b0, 1'b1, 5'b00100},
    {5'b10100, 5'b00011, 1'b1, 1'b0, 5'b00100},
    {5'b10100, 5'b00011, 1'b1, 1'b1, 5'b10000},
    {5'b10100, 5'b00011, 1'b0, 1'b0, 5'b10000},
    {5'b00100, 5'b00011, 1'b0, 1'b0, 5'b00000},
    {5'b00100, 5'b00011, 1'b0, 1'b0, 5'b00100},
    {5'b00000, 5'b00011, 1'b0, 1'b0, 5'b00000}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R2";  1: return "R4";  2: return "R7";  3: return "R3";
      4: return "R6";  5: return "R9";  6: return "R9";  7: return "R6";
      8: return "R4";  9: return "R4";  10: return "R8"; 11: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string tag, logic [N-1:0] exp);
    n_vec++;
    if (~gnt_no !== exp) begin
      n_bad++;
      $display("FAIL %s: grant %b expected %b at %0t", tag, ~gnt_no, exp, $time);
    end
  endtask

  // drive at a falling edge, result visible at the next falling edge
  task automatic step(logic [N-1:0] req, logic frame, logic irdy,
                      string tag, logic [N-1:0] exp);
    req_ni   = ~req;
    frame_ni = ~frame;
    irdy_ni  = ~irdy;
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic do_reset(logic [N-1:0] grp);
    rst_ni   = 1'b0;
    hi_grp_i = grp;
    req_ni   = '0;
    frame_ni = 1'b1;
    irdy_ni  = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", '0);
    req_ni = '1;
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic rot_case(logic [N-1:0] grp);
    do_reset(grp);
    step(5'b11111, 1'b0, 1'b0, "R5", 5'b00001);
    step(5'b11111, 1'b1, 1'b0, "R5", 5'b00001);
    step(5'b11111, 1'b1, 1'b1, "R5", 5'b00010);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got %0d expected completion", n_vec);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(5'b00011);
    check("R1", '0);

    for (int i = 0; i < NV; i++) begin
      hi_grp_i = VEC[i][11:7];
      step(VEC[i][16:12], VEC[i][6], VEC[i][5], vec_tag(i), VEC[i][4:0]);
    end

    // plain rotation with all masters in one group
    rot_case(5'b11111);
    rot_case(5'b00000);

    // high group member beats low group member after reset
    do_reset(5'b00011);
    step(5'b00110, 1'b0, 1'b0, "R3", 5'b00010);

    // timeout and lockout on master 3
    do_reset(5'b00011);
    step(5'b01000, 1'b0, 1'b0, "R10", 5'b01000);
    for (int c = 0; c < 15; c++)
      step(5'b01000, 1'b0, 1'b0, "R10", 5'b01000);
    step(5'b01000, 1'b0, 1'b0, "R10", 5'b00000);
    step(5'b01000, 1'b0, 1'b0, "R11", 5'b00000);
    step(5'b01000, 1'b0, 1'b0, "R11", 5'b00000);
    step(5'b00000, 1'b0, 1'b0, "R11", 5'b00000);
    step(5'b01000, 1'b0, 1'b0, "R11", 5'b01000);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule